// File: doc/BRIEF.md
# Passive STN LCD refresh streamer

This block refreshes a passive-matrix STN panel that is driven through an external shift-register column driver. Software first sets the source start address, the pixel depth, the panel width in pixels, the number of rows, the output bus width, the output ordering and the base-clock divider. It then pulses `start`. The block raises a bus request that holds the CPU off the memory bus. It reads the whole frame into an internal buffer with a simple request/grant/valid handshake, one byte at a time, and then drops the request.

With the bus released, the block plays the buffered frame out to the panel driver on a dedicated data bus that is 4 or 8 bits wide. Every word on that bus comes with a one-cycle shift-clock pulse. Each row ends with a line-latch period, and the frame strobe marks the words of the first row. The alternation signal flips once per frame. All of this runs at a base rate that comes from a divide-by-16 prescaler followed by an 8-bit programmable counter.

Top module: `stn_refresh_streamer`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `lcd_cp`, `lcd_lp`, `lcd_fr`, `lcd_ac` and `lcd_data` are all 0. A `start` pulse seen while the block is idle latches all `cfg_*` inputs, and `bus_req` is 1 two clock cycles after the edge that samples `start`.
- R2: The frame holds `rows × ceil(width × bpp / 8)` bytes. These are read one request at a time with `mem_rd` pulses at consecutive addresses, beginning at `cfg_addr`. `mem_rd` is only asserted while `bus_req` is 1 and `mem_gnt` is 1. Each read is completed by a `mem_rvalid` pulse that carries `mem_rdata`.
- R3: `bus_req` falls once the last byte of the frame has been received. No shift-clock pulse occurs while `bus_req` is 1.
- R4: With `cfg_bus8`=0, each byte goes out as two 4-bit words on `lcd_data[3:0]` while `lcd_data[7:4]` stays 0. `cfg_order`=0 sends the high nibble first and `cfg_order`=1 sends the low nibble first.
- R5: With `cfg_bus8`=1, each byte goes out as one 8-bit word. `cfg_order`=0 sends it unchanged (stored bit 7 on `lcd_data[7]`). `cfg_order`=1 sends it bit-reversed (stored bit 7 on `lcd_data[0]`).
- R6: `cfg_depth` encodes bits per pixel as 0→1, 1→2, 2→3, 3→4, 4→8 and 5→12, and 6 or 7 are treated as 1. Each row's byte count is rounded up to whole bytes.
- R7: The base period is `16 × (cfg_div + 1)` clock cycles. Each data word occupies one base period and is accompanied by a one-cycle `lcd_cp` pulse in the cycle in which `lcd_data` takes the new word.
- R8: After the last word of every row, `lcd_lp` is 1 for exactly one base period with no `lcd_cp` pulse. This makes the gap between the last word of a row and the first word of the next row two base periods.
- R9: `lcd_fr` is 1 at the shift pulses of the first row's words and 0 at the shift pulses of all later rows.
- R10: `lcd_ac` toggles exactly once per frame. It toggles at the end of the frame, in the cycle where `lcd_lp` falls after the last row.
- R11: If `mem_gnt` stays 0, the block keeps `bus_req` at 1 and issues no read for as long as the grant is withheld, with no timeout. Once the grant arrives it completes the frame normally.
- R12: A `start` pulse while a frame is being fetched or sent is ignored. The running frame still uses its original configuration, and no further fetch follows once it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| cfg_addr | input | ADDR_W | Source start address |
| cfg_width | input | WID_W | Panel width in pixels |
| cfg_rows | input | ROW_W | Panel rows |
| cfg_depth | input | 3 | Pixel depth code |
| cfg_bus8 | input | 1 | 1: 8-bit output bus, 0: 4-bit |
| cfg_order | input | 1 | Output ordering select |
| cfg_div | input | DIV_W | Base-clock divider |
| bus_req | output | 1 | Bus request that stalls the CPU |
| mem_gnt | input | 1 | Bus grant |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| lcd_data | output | 8 | Panel driver data bus |
| lcd_cp | output | 1 | Shift clock pulse |
| lcd_lp | output | 1 | Line latch |
| lcd_fr | output | 1 | Frame strobe |
| lcd_ac | output | 1 | Alternation signal |

## Verification
The hardest situations to reach from the ports are a grant that never arrives and a start written in the middle of a frame. The bench holds `mem_gnt` low for thousands of cycles after a start and watches for reads or shift pulses, then releases the grant and checks that the frame completes intact. For the second case it waits for the first shift pulse of a running frame, pulses `start` with a different address, and checks three things: the streamed words still follow the original address, the read count stays at one frame, and `bus_req` stays low afterwards.

// File: rtl/stn_pkg.sv
package stn_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} ctl_state_t;
  typedef enum logic [1:0] {PH_DATA, PH_LATCH, PH_END} row_phase_t;
  typedef enum logic [1:0] {FT_IDLE, FT_ISSUE, FT_WAIT} fetch_state_t;

  // pixel depth code to bits per pixel
  function automatic logic [3:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd1:    depth_bits = 4'd2;
      3'd2:    depth_bits = 4'd3;
      3'd3:    depth_bits = 4'd4;
      3'd4:    depth_bits = 4'd8;
      3'd5:    depth_bits = 4'd12;
      default: depth_bits = 4'd1;
    endcase
  endfunction

  function automatic logic [7:0] bit_rev(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bit_rev[i] = b[7-i];
  endfunction

endpackage

// File: rtl/stn_clkgen.sv
module stn_clkgen #(
  parameter int PRE   = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = $clog2(PRE);

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pre_cnt == PRE_W'(PRE - 1)) begin
        pre_cnt <= '0;
        if (div_cnt == div) begin
          div_cnt <= '0;
          tick    <= 1'b1;
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stn_fetch.sv
module stn_fetch
  import stn_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int TOT_W  = 15,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [TOT_W-1:0]  total,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              bus_req,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              done
);
  fetch_state_t     st;
  logic [TOT_W-1:0] cnt;

  assign wr_en   = (st == FT_WAIT) && mem_rvalid;
  assign wr_addr = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FT_IDLE;
      cnt      <= '0;
      bus_req  <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      done   <= 1'b0;
      case (st)
        FT_IDLE: if (go) begin
          bus_req <= 1'b1;
          cnt     <= '0;
          st      <= FT_ISSUE;
        end
        FT_ISSUE: if (mem_gnt) begin
          mem_rd   <= 1'b1;
          mem_addr <= base + ADDR_W'(cnt);
          st       <= FT_WAIT;
        end
        FT_WAIT: if (mem_rvalid) begin
          cnt <= cnt + 1'b1;
          if (cnt + 1'b1 == total) begin
            bus_req <= 1'b0;
            done    <= 1'b1;
            st      <= FT_IDLE;
          end else begin
            st <= FT_ISSUE;
          end
        end
        default: st <= FT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stn_framebuf.sv
module stn_framebuf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stn_shifter.sv
module stn_shifter
  import stn_pkg::*;
#(
  parameter int AW    = 6,
  parameter int WPR_W = 10,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             tick,
  input  logic             bus8,
  input  logic             order,
  input  logic [WPR_W-1:0] wpr,
  input  logic [ROW_W-1:0] rows,
  input  logic [7:0]       byte_q,
  output logic [AW-1:0]    bptr,
  output logic [7:0]       lcd_data,
  output logic             lcd_cp,
  output logic             lcd_lp,
  output logic             lcd_fr,
  output logic             lcd_ac,
  output logic             done
);
  row_phase_t       ph;
  logic             active, half;
  logic [WPR_W-1:0] wc;
  logic [ROW_W-1:0] row;
  logic [7:0]       word;

  always_comb begin
    if (bus8) word = order ? bit_rev(byte_q) : byte_q;
    else      word = {4'd0, (half ^ order) ? byte_q[3:0] : byte_q[7:4]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_DATA; active <= 1'b0; half <= 1'b0;
      wc <= '0; row <= '0; bptr <= '0;
      lcd_data <= '0; lcd_cp <= 1'b0; lcd_lp <= 1'b0;
      lcd_fr <= 1'b0; lcd_ac <= 1'b0; done <= 1'b0;
    end else begin
      lcd_cp <= 1'b0;
      done   <= 1'b0;
      if (go) begin
        ph <= PH_DATA; active <= 1'b1; half <= 1'b0;
        wc <= '0; row <= '0; bptr <= '0;
      end else if (active && tick) begin
        case (ph)
          PH_DATA: begin
            lcd_data <= word;
            lcd_cp   <= 1'b1;
            lcd_lp   <= 1'b0;
            lcd_fr   <= (row == '0);
            if (bus8 || half) begin
              bptr <= bptr + 1'b1;
              half <= 1'b0;
            end else begin
              half <= 1'b1;
            end
            if (wc == wpr - 1'b1) begin
              wc <= '0;
              ph <= PH_LATCH;
            end else begin
              wc <= wc + 1'b1;
            end
          end
          PH_LATCH: begin
            lcd_lp <= 1'b1;
            if (row == rows - 1'b1) ph <= PH_END;
            else begin
              row <= row + 1'b1;
              ph  <= PH_DATA;
            end
          end
          default: begin
            lcd_lp <= 1'b0;
            lcd_fr <= 1'b0;
            lcd_ac <= ~lcd_ac;
            active <= 1'b0;
            done   <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/stn_refresh_streamer.sv
module stn_refresh_streamer
  import stn_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WID_W  = 8,
  parameter int ROW_W  = 6,
  parameter int DIV_W  = 8,
  parameter int DEPTH  = 64,
  parameter int PRE    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_bus8,
  input  logic              cfg_order,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              bus_req,
  input  logic              mem_gnt,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        lcd_data,
  output logic              lcd_cp,
  output logic              lcd_lp,
  output logic              lcd_fr,
  output logic              lcd_ac
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PROD_W = WID_W + 4;
  localparam int BPR_W  = PROD_W - 2;
  localparam int WPR_W  = BPR_W + 1;
  localparam int TOT_W  = BPR_W + ROW_W;

  ctl_state_t        st;
  logic [ADDR_W-1:0] base_q;
  logic [ROW_W-1:0]  rows_q;
  logic [BPR_W-1:0]  bpr_q;
  logic [DIV_W-1:0]  div_q;
  logic              bus8_q, order_q;
  logic              fetch_go, stream_go, fetch_done, stream_done, tick;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [7:0]        byte_q;
  logic [PROD_W-1:0] row_bits;
  logic [TOT_W-1:0]  total;
  logic [WPR_W-1:0]  wpr;

  assign row_bits = PROD_W'(cfg_width) * PROD_W'(depth_bits(cfg_depth)) + PROD_W'(7);
  assign total    = TOT_W'(bpr_q) * TOT_W'(rows_q);
  assign wpr      = bus8_q ? WPR_W'(bpr_q) : {bpr_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fetch_go <= 1'b0; stream_go <= 1'b0;
      base_q <= '0; rows_q <= '0; bpr_q <= '0; div_q <= '0;
      bus8_q <= 1'b0; order_q <= 1'b0;
    end else begin
      fetch_go  <= 1'b0;
      stream_go <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          base_q   <= cfg_addr;
          rows_q   <= cfg_rows;
          bpr_q    <= BPR_W'(row_bits >> 3);
          div_q    <= cfg_div;
          bus8_q   <= cfg_bus8;
          order_q  <= cfg_order;
          fetch_go <= 1'b1;
          st       <= ST_FETCH;
        end
        ST_FETCH: if (fetch_done) begin
          stream_go <= 1'b1;
          st        <= ST_SEND;
        end
        ST_SEND: if (stream_done) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  stn_fetch #(.ADDR_W(ADDR_W), .TOT_W(TOT_W), .AW(AW)) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go), .base(base_q), .total(total),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .bus_req(bus_req),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .done(fetch_done)
  );

  stn_framebuf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(mem_rdata),
    .raddr(rd_addr), .rdata(byte_q)
  );

  stn_clkgen #(.PRE(PRE), .DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(st == ST_SEND), .div(div_q), .tick(tick)
  );

  stn_shifter #(.AW(AW), .WPR_W(WPR_W), .ROW_W(ROW_W)) u_shift (
    .clk(clk), .rst(rst), .go(stream_go), .tick(tick), .bus8(bus8_q),
    .order(order_q), .wpr(wpr), .rows(rows_q), .byte_q(byte_q),
    .bptr(rd_addr), .lcd_data(lcd_data), .lcd_cp(lcd_cp), .lcd_lp(lcd_lp),
    .lcd_fr(lcd_fr), .lcd_ac(lcd_ac), .done(stream_done)
  );
endmodule

// File: rtl/stn_refresh_checker.sv
module stn_refresh_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       mem_rd,
  input logic       lcd_cp,
  input logic       lcd_lp,
  input logic       lcd_ac,
  input logic       bus8_q,
  input logic [7:0] lcd_data
);
  // R2
  a_r2_read_under_request: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> bus_req);
  // R3
  a_r3_quiet_during_fetch: assert property (@(posedge clk) disable iff (rst)
    lcd_cp |-> !bus_req);
  // R4
  a_r4_narrow_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (lcd_cp && !bus8_q) |-> (lcd_data[7:4] == 4'd0));
  // R7
  a_r7_cp_single_cycle: assert property (@(posedge clk) disable iff (rst)
    lcd_cp |=> !lcd_cp);
  // R8
  a_r8_latch_without_shift: assert property (@(posedge clk) disable iff (rst)
    lcd_lp |-> !lcd_cp);
  // R10
  a_r10_ac_at_frame_end: assert property (@(posedge clk) disable iff (rst)
    (lcd_ac != $past(lcd_ac)) |-> $fell(lcd_lp));
endmodule

bind stn_refresh_streamer stn_refresh_checker u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .mem_rd(mem_rd),
  .lcd_cp(lcd_cp), .lcd_lp(lcd_lp), .lcd_ac(lcd_ac),
  .bus8_q(bus8_q), .lcd_data(lcd_data)
);

// File: tb/stn_refresh_streamer_test.sv
module stn_refresh_streamer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_width = '0;
  logic [5:0]  cfg_rows = '0;
  logic [2:0]  cfg_depth = '0;
  logic        cfg_bus8 = 1'b0, cfg_order = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        bus_req, mem_rd, mem_gnt = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  lcd_data;
  logic        lcd_cp, lcd_lp, lcd_fr, lcd_ac;

  always #2.5 clk = ~clk;

  stn_refresh_streamer uut (
    .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr),
    .cfg_width(cfg_width), .cfg_rows(cfg_rows), .cfg_depth(cfg_depth),
    .cfg_bus8(cfg_bus8), .cfg_order(cfg_order), .cfg_div(cfg_div),
    .bus_req(bus_req), .mem_gnt(mem_gnt), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .lcd_data(lcd_data), .lcd_cp(lcd_cp), .lcd_lp(lcd_lp),
    .lcd_fr(lcd_fr), .lcd_ac(lcd_ac)
  );

  function automatic logic [7:0] mdata(input logic [15:0] a);
    mdata = (a[7:0] * 8'd37 + 8'h5A) ^ a[15:8];
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mdata(mem_addr);
  end

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitors
  logic [7:0]  cap [0:511];
  bit          capfr [0:511];
  int          n_words, lp_rises, lp_cycles, gaps1, gaps2, gap_bad, req_bad;
  int          rd_count, addr_bad, last_cp, per;
  logic [15:0] exp_addr;
  bit          prev_lp;

  always @(negedge clk) begin
    if (!rst) begin
      if (lcd_cp) begin
        if (n_words < 512) begin
          cap[n_words]   = lcd_data;
          capfr[n_words] = lcd_fr;
        end
        if (bus_req) req_bad++;
        if (n_words > 0) begin
          if (cyc - last_cp == per) gaps1++;
          else if (cyc - last_cp == 2 * per) gaps2++;
          else gap_bad++;
        end
        last_cp = cyc;
        n_words++;
      end
      if (lcd_lp) lp_cycles++;
      if (lcd_lp && !prev_lp) lp_rises++;
      prev_lp = lcd_lp;
      if (mem_rd) begin
        if (mem_addr != exp_addr || !bus_req || !mem_gnt) addr_bad++;
        exp_addr = exp_addr + 16'd1;
        rd_count++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // vector fields: addr16 width8 rows6 depth3 bus8 order div8
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {16'h0100, 8'd8, 6'd2, 3'd0, 1'b0, 1'b0, 8'd0},
    {16'h0230, 8'd4, 6'd3, 3'd1, 1'b0, 1'b1, 8'd1},
    {16'h1000, 8'd8, 6'd2, 3'd2, 1'b1, 1'b0, 8'd0},
    {16'h00F0, 8'd5, 6'd2, 3'd3, 1'b1, 1'b1, 8'd0},
    {16'h4000, 8'd3, 6'd4, 3'd4, 1'b0, 1'b0, 8'd2},
    {16'h7F00, 8'd4, 6'd2, 3'd5, 1'b0, 1'b1, 8'd0},
    {16'h00FE, 8'd8, 6'd1, 3'd0, 1'b1, 1'b0, 8'd0}
  };

  // mode 0: plain, 1: withhold grant first, 2: extra start while running
  task automatic run_frame(input logic [42:0] v, input int mode);
    int bpp, bpr, total, wpr, nexp, bad_w, bad_fr, first_bad, ac0, rd_keep;
    logic [7:0] expw [0:511];
    logic [7:0] b;
    {cfg_addr, cfg_width, cfg_rows, cfg_depth, cfg_bus8, cfg_order, cfg_div} = v;
    case (cfg_depth)
      3'd1: bpp = 2; 3'd2: bpp = 3; 3'd3: bpp = 4;
      3'd4: bpp = 8; 3'd5: bpp = 12; default: bpp = 1;
    endcase
    bpr   = (int'(cfg_width) * bpp + 7) / 8;      // R6
    total = bpr * int'(cfg_rows);
    wpr   = cfg_bus8 ? bpr : 2 * bpr;
    per   = 16 * (int'(cfg_div) + 1);
    nexp  = 0;
    for (int i = 0; i < total; i++) begin
      b = mdata(cfg_addr + 16'(i));
      if (cfg_bus8) begin
        for (int k = 0; k < 8; k++) expw[nexp][k] = cfg_order ? b[7-k] : b[k];
        nexp++;
      end else begin
        expw[nexp]   = {4'd0, cfg_order ? b[3:0] : b[7:4]};
        expw[nexp+1] = {4'd0, cfg_order ? b[7:4] : b[3:0]};
        nexp += 2;
      end
    end
    n_words = 0; lp_rises = 0; lp_cycles = 0; gaps1 = 0; gaps2 = 0;
    gap_bad = 0; req_bad = 0; rd_count = 0; addr_bad = 0;
    exp_addr = cfg_addr;
    ac0 = int'(lcd_ac);
    if (mode == 1) mem_gnt = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    check(bus_req == 1'b1, "R1", "bus_req two cycles after start", int'(bus_req), 1);
    if (mode == 1) begin
      repeat (3000) @(negedge clk);
      check(bus_req == 1'b1 && rd_count == 0 && n_words == 0, "R11",
            "request held without grant, reads", rd_count, 0);
      mem_gnt = 1'b1;
    end
    if (mode == 2) begin
      while (n_words == 0) @(negedge clk);
      cfg_addr = 16'h5555;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (int'(lcd_ac) == ac0) @(negedge clk);
    check(1'b1, "R10", "alternation toggled", 1, 1);
    bad_w = 0; bad_fr = 0; first_bad = -1;
    for (int i = 0; i < nexp && i < n_words; i++) begin
      if (cap[i] != expw[i]) begin
        bad_w++;
        if (first_bad < 0) first_bad = i;
      end
      if (capfr[i] != (i < wpr)) bad_fr++;
    end
    check(n_words == nexp, "R6", "word count", n_words, nexp);
    if (first_bad >= 0)
      check(1'b0, cfg_bus8 ? "R5" : "R4", "word value",
            int'(cap[first_bad]), int'(expw[first_bad]));
    else
      check(1'b1, cfg_bus8 ? "R5" : "R4", "word values", 0, 0);
    check(bad_fr == 0, "R9", "frame strobe mismatches", bad_fr, 0);
    check(rd_count == total, "R2", "reads issued", rd_count, total);
    check(addr_bad == 0, "R2", "read address errors", addr_bad, 0);
    check(req_bad == 0, "R3", "shift pulses during request", req_bad, 0);
    check(gap_bad == 0 && gaps2 == int'(cfg_rows) - 1, "R7",
          "word spacing bad/row gaps", gap_bad, 0);
    check(lp_rises == int'(cfg_rows), "R8", "line latch count", lp_rises,
          int'(cfg_rows));
    check(lp_cycles == int'(cfg_rows) * per, "R8", "line latch cycles",
          lp_cycles, int'(cfg_rows) * per);
    check(lcd_fr == 1'b0, "R9", "frame strobe low after frame", int'(lcd_fr), 0);
    if (mode == 2) begin
      rd_keep = rd_count;
      repeat (200) @(negedge clk);
      check(bus_req == 1'b0 && rd_count == rd_keep, "R12",
            "no fetch after ignored start", rd_count, rd_keep);
    end
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({bus_req, mem_rd, lcd_cp, lcd_lp, lcd_fr, lcd_ac} == 6'd0 &&
          lcd_data == 8'd0, "R1", "reset outputs", int'(lcd_data), 0);
    for (int i = 0; i < NV; i++) run_frame(VEC[i], 0);
    run_frame(VEC[2], 1);
    run_frame(VEC[4], 2);
    run_frame(VEC[1], 2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule